// File: doc/BRIEF.md
# Timer Update Event Controller

This block is the counting core of a general-purpose timer. It holds a prescaler and an up/down counter. Three values (auto-reload limit, prescaler divider, compare level) sit in two stages: a preload copy that software writes at any time, and an active shadow copy that the timer logic uses. The block decides when an update event occurs, when the shadow copies take their preload values, and when a sticky update flag, with its interrupt and DMA request outputs, is raised.

An update can come from counter wrap (overflow when counting up, underflow when counting down), from a software update strobe, or from a slave-mode reset pulse. A source-filter input limits the flag to wrap events only. An update-inhibit input blocks the event entirely, so the shadows and the flag are untouched, yet the software strobe and the slave reset still restart the counter and the prescaler. A slave-mode trigger pulse starts the counter without a software write.

Top module: `tmr_update_ctrl`

## Requirements
- R1: While the run state is 0 and no restart is requested, the counter and the prescaler hold their values.
- R2: A pulse on `slv_trig_i` sets the run state to 1 on the next clock edge. This takes priority over a same-cycle software write of the run state.
- R3: With the run state at 1 and the prescaler shadow at P, the counter moves once every P+1 clocks. When counting up (`dir_i`=0), it goes from the auto-reload shadow value back to 0, and that step is an overflow.
- R4: When counting down (`dir_i`=1), the counter goes from 0 to the auto-reload shadow value, and that step is an underflow.
- R5: With `upd_inh_i`=0, every update event (wrap, `sw_upd_i`, `slv_rst_i`) copies all three preload values into their shadows on that edge. Preload writes are not visible on the shadow outputs before such an event.
- R6: With `upd_inh_i`=1, no update event occurs: the shadow outputs keep their values and the update flag is not set.
- R7: `sw_upd_i` or `slv_rst_i` restarts the counting regardless of `upd_inh_i`: the prescaler goes to 0, and the counter goes to 0 when counting up or to the auto-reload shadow value when counting down.
- R8: With `wrap_only_i`=0, an update event from any source sets the update flag. With `wrap_only_i`=1, only an overflow or underflow sets it.
- R9: The update flag resets to 0, stays set until `flag_clr_i` is pulsed, and a same-cycle set wins over the clear. `irq_o` is the flag AND `irq_en_i`. `dma_o` is the flag AND `dma_en_i`.
- R10: A software strobe in the same cycle as an up-count overflow gives one update event. The counter ends at 0 and the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_wr_i | input | 1 | Software write strobe for the run state |
| run_wd_i | input | 1 | Run state value to write |
| dir_i | input | 1 | Count direction, 0 up, 1 down |
| wrap_only_i | input | 1 | Restrict flag to overflow/underflow |
| upd_inh_i | input | 1 | Inhibit update events |
| sw_upd_i | input | 1 | Software update strobe |
| slv_rst_i | input | 1 | Slave-mode reset pulse |
| slv_trig_i | input | 1 | Slave-mode trigger pulse (starts counter) |
| lim_wr_i | input | 1 | Auto-reload preload write strobe |
| lim_wd_i | input | CNT_W | Auto-reload preload data |
| div_wr_i | input | 1 | Prescaler preload write strobe |
| div_wd_i | input | PSC_W | Prescaler preload data |
| cmp_wr_i | input | 1 | Compare preload write strobe |
| cmp_wd_i | input | CMP_W | Compare preload data |
| flag_clr_i | input | 1 | Write-one-to-clear for the update flag |
| irq_en_i | input | 1 | Interrupt enable |
| dma_en_i | input | 1 | DMA request enable |
| cnt_o | output | CNT_W | Counter value |
| lim_o | output | CNT_W | Active auto-reload value |
| div_o | output | PSC_W | Active prescaler divider |
| cmp_o | output | CMP_W | Active compare value |
| run_o | output | 1 | Run state |
| flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Update interrupt request |
| dma_o | output | 1 | Update DMA request |

## Verification
The software update strobe and a counter overflow can occur in the same cycle. They could then produce two reloads, or a counter left at a non-zero value. The bench runs a reference model alongside the design and waits until the model predicts an overflow edge, then raises the strobe in exactly that cycle. It checks that the counter lands on 0, the flag is set and the shadows hold the preload values. The source filter is judged in the same way, by placing a software strobe on a non-wrap cycle while wrap-only mode is set and checking that the flag stays clear.

// File: rtl/tmr_pkg.sv
// Package: shared types for the timer update controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package tmr_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } tmr_dir_e;

    // Causes that may fire an update event in one cycle.
    typedef struct packed {
        logic wrap;
        logic sw;
        logic slv;
    } upd_cause_t;

    // True when any cause is present.
    function automatic logic any_cause(input upd_cause_t c);
        return c.wrap | c.sw | c.slv;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: counts enabled cycles from 0 to div_i and gives one tick
// when the count equals div_i. Assumes div_i changes only on a cycle
// where the count restarts (tick or clear), so the equality is always reached.
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] pcnt_q;

    assign tick_o = run_i && (pcnt_q == div_i);

    // Advance, wrap or clear the prescale count.
    always_ff @(posedge clk) begin
        if (!rst_n)       pcnt_q <= '0;
        else if (clr_i)   pcnt_q <= '0;
        else if (tick_o)  pcnt_q <= '0;
        else if (run_i)   pcnt_q <= pcnt_q + 1'b1;
    end

    AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(pcnt_q)); // R1
    AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pcnt_q == '0)); // R7
endmodule

// File: rtl/tmr_counter.sv
// Up/down main counter: steps on each prescaler tick and reports a wrap
// (overflow up, underflow down). A restart loads 0 (up) or the limit (down).
// Assumes reinit_i has priority over tick_i.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reinit_i,
    input  tmr_dir_e         dir_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic             at_edge;

    assign at_edge = (dir_i == DIR_DOWN) ? (cnt_q == ZERO) : (cnt_q == lim_i);
    assign wrap_o  = tick_i && at_edge;
    assign cnt_o   = cnt_q;

    // Step, wrap or restart the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (reinit_i) begin
            cnt_q <= (dir_i == DIR_DOWN) ? lim_i : ZERO;
        end else if (tick_i) begin
            if (dir_i == DIR_DOWN) cnt_q <= at_edge ? lim_i : cnt_q - 1'b1;
            else                   cnt_q <= at_edge ? ZERO  : cnt_q + 1'b1;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !reinit_i) |=> $stable(cnt_q)); // R1
    AST_RESTART_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit_i && dir_i == DIR_UP) |=> (cnt_q == ZERO)); // R7
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !reinit_i && dir_i == DIR_UP) |=> (cnt_q == ZERO)); // R3
endmodule

// File: rtl/tmr_preload.sv
// Two-stage register: software writes the preload stage; the active
// shadow stage copies it only on load_i. Assumes load_i is a one-cycle event.
module tmr_preload #(
    parameter int              W       = 16,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wd_i,
    input  logic         load_i,
    output logic [W-1:0] sh_o
);
    logic [W-1:0] pre_q;
    logic [W-1:0] sh_q;

    // Capture software writes into the preload stage.
    always_ff @(posedge clk) begin
        if (!rst_n)     pre_q <= RST_VAL;
        else if (wr_i)  pre_q <= wd_i;
    end

    // Transfer preload into the shadow on an update event.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= RST_VAL;
        else if (load_i)  sh_q <= pre_q;
    end

    assign sh_o = sh_q;

    AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(sh_q)); // R6
    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sh_q == $past(pre_q))); // R5
endmodule

// File: rtl/tmr_update_ctrl.sv
// Timer update event controller (top). Combines prescaler, counter and the
// three preload/shadow pairs; decides update events, shadow reloads and the
// sticky flag with its interrupt and DMA requests.
// Assumes all strobes are single-cycle pulses synchronous to clk.
module tmr_update_ctrl
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_wr_i,
    input  logic             run_wd_i,
    input  logic             dir_i,
    input  logic             wrap_only_i,
    input  logic             upd_inh_i,
    input  logic             sw_upd_i,
    input  logic             slv_rst_i,
    input  logic             slv_trig_i,
    input  logic             lim_wr_i,
    input  logic [CNT_W-1:0] lim_wd_i,
    input  logic             div_wr_i,
    input  logic [PSC_W-1:0] div_wd_i,
    input  logic             cmp_wr_i,
    input  logic [CMP_W-1:0] cmp_wd_i,
    input  logic             flag_clr_i,
    input  logic             irq_en_i,
    input  logic             dma_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] lim_o,
    output logic [PSC_W-1:0] div_o,
    output logic [CMP_W-1:0] cmp_o,
    output logic             run_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             dma_o
);
    localparam logic [CNT_W-1:0] LIM_RST = '1;

    tmr_dir_e   dir;
    upd_cause_t cause;
    logic       run_q;
    logic       flag_q;
    logic       tick;
    logic       wrap;
    logic       reinit;
    logic       upd_ev;
    logic       flag_set;

    assign dir    = tmr_dir_e'(dir_i);
    assign reinit = sw_upd_i | slv_rst_i;
    assign cause  = '{wrap: wrap, sw: sw_upd_i, slv: slv_rst_i};

    // One event per cycle however many causes coincide; inhibit blocks it.
    assign upd_ev   = !upd_inh_i && any_cause(cause);
    assign flag_set = upd_ev && (!wrap_only_i || cause.wrap);

    // Run state: trigger sets it, software writes it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b0;
        else if (slv_trig_i) run_q <= 1'b1;
        else if (run_wr_i)   run_q <= run_wd_i;
    end

    // Sticky update flag; a set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (flag_set)   flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_q),
        .clr_i  (reinit),
        .div_i  (div_o),
        .tick_o (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .reinit_i (reinit),
        .dir_i    (dir),
        .lim_i    (lim_o),
        .cnt_o    (cnt_o),
        .wrap_o   (wrap)
    );

    tmr_preload #(.W(CNT_W), .RST_VAL(LIM_RST)) u_lim (
        .clk (clk), .rst_n (rst_n), .wr_i (lim_wr_i), .wd_i (lim_wd_i),
        .load_i (upd_ev), .sh_o (lim_o)
    );

    tmr_preload #(.W(PSC_W), .RST_VAL('0)) u_div (
        .clk (clk), .rst_n (rst_n), .wr_i (div_wr_i), .wd_i (div_wd_i),
        .load_i (upd_ev), .sh_o (div_o)
    );

    tmr_preload #(.W(CMP_W), .RST_VAL('0)) u_cmp (
        .clk (clk), .rst_n (rst_n), .wr_i (cmp_wr_i), .wd_i (cmp_wd_i),
        .load_i (upd_ev), .sh_o (cmp_o)
    );

    assign run_o  = run_q;
    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;
    assign dma_o  = flag_q & dma_en_i;

    AST_TRIG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        slv_trig_i |=> run_o); // R2
    AST_INHIBIT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_inh_i && !flag_o) |=> !flag_o); // R6
    AST_SRC_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_only_i && !wrap && !flag_o) |=> !flag_o); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o); // R9
    AST_SW_AT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_upd_i && wrap && dir == DIR_UP && !upd_inh_i) |=> (cnt_o == '0 && flag_o)); // R10
endmodule

// File: tb/tb_tmr_update_ctrl.sv
// Scoreboard bench: the driver applies one cycle of stimulus, steps a
// reference model built from the requirements and queues the expected
// outputs; the monitor pops and compares after each rising edge.
module tb_tmr_update_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_wr = 0, run_wd = 0, dir = 0, wrap_only = 0, upd_inh = 0;
    logic        sw_upd = 0, slv_rst = 0, slv_trig = 0;
    logic        lim_wr = 0, div_wr = 0, cmp_wr = 0, flag_clr = 0;
    logic        irq_en = 0, dma_en = 0;
    logic [15:0] lim_wd = 0, div_wd = 0, cmp_wd = 0;
    logic [15:0] cnt, lim, div, cmp;
    logic        run, flag, irq, dma;

    always #10 clk = ~clk; // 50 MHz

    tmr_update_ctrl dut (
        .clk (clk), .rst_n (rst_n), .run_wr_i (run_wr), .run_wd_i (run_wd),
        .dir_i (dir), .wrap_only_i (wrap_only), .upd_inh_i (upd_inh),
        .sw_upd_i (sw_upd), .slv_rst_i (slv_rst), .slv_trig_i (slv_trig),
        .lim_wr_i (lim_wr), .lim_wd_i (lim_wd), .div_wr_i (div_wr), .div_wd_i (div_wd),
        .cmp_wr_i (cmp_wr), .cmp_wd_i (cmp_wd), .flag_clr_i (flag_clr),
        .irq_en_i (irq_en), .dma_en_i (dma_en), .cnt_o (cnt), .lim_o (lim),
        .div_o (div), .cmp_o (cmp), .run_o (run), .flag_o (flag), .irq_o (irq), .dma_o (dma)
    );

    typedef struct {
        string       tag;
        logic [15:0] cnt, lim, div, cmp;
        logic        run, flag, irq, dma;
    } vec_t;

    vec_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;

    // Reference model state
    logic        m_run, m_flag;
    logic [15:0] m_pcnt, m_cnt, m_lim, m_div, m_cmp, p_lim, p_div, p_cmp;

    // Step the model over one edge and queue the expected post-edge outputs.
    task automatic step(input string tag);
        logic tick, wrap, rein, ev, fset;
        vec_t v;
        if (!rst_n) begin
            m_run = 0; m_flag = 0; m_pcnt = 0; m_cnt = 0;
            m_lim = 16'hFFFF; p_lim = 16'hFFFF; m_div = 0; p_div = 0; m_cmp = 0; p_cmp = 0;
        end else begin
            tick = m_run && (m_pcnt == m_div);
            wrap = tick && (dir ? (m_cnt == 0) : (m_cnt == m_lim));
            rein = sw_upd || slv_rst;
            ev   = !upd_inh && (wrap || rein);
            fset = ev && (!wrap_only || wrap);
            if (rein)      m_cnt = dir ? m_lim : 16'd0;
            else if (tick) m_cnt = dir ? ((m_cnt == 0) ? m_lim : m_cnt - 1)
                                       : ((m_cnt == m_lim) ? 16'd0 : m_cnt + 1);
            if (rein || tick) m_pcnt = 0;
            else if (m_run)   m_pcnt = m_pcnt + 1;
            if (slv_trig)    m_run = 1;
            else if (run_wr) m_run = run_wd;
            if (ev) begin m_lim = p_lim; m_div = p_div; m_cmp = p_cmp; end
            if (lim_wr) p_lim = lim_wd;
            if (div_wr) p_div = div_wd;
            if (cmp_wr) p_cmp = cmp_wd;
            if (fset)          m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
        v.tag = tag; v.cnt = m_cnt; v.lim = m_lim; v.div = m_div; v.cmp = m_cmp;
        v.run = m_run; v.flag = m_flag; v.irq = m_flag & irq_en; v.dma = m_flag & dma_en;
        q.push_back(v);
        @(negedge clk);
        run_wr = 0; sw_upd = 0; slv_rst = 0; slv_trig = 0;
        lim_wr = 0; div_wr = 0; cmp_wr = 0; flag_clr = 0;
    endtask

    task automatic steps(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // Monitor: compare one queued vector per edge, mid high phase.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                vec_t v;
                logic bad;
                v = q.pop_front();
                n_vec++;
                bad = 0;
                if (cnt !== v.cnt)   begin bad = 1; $display("FAIL %s cnt act=%0d exp=%0d", v.tag, cnt, v.cnt); end
                if (lim !== v.lim)   begin bad = 1; $display("FAIL %s lim act=%0d exp=%0d", v.tag, lim, v.lim); end
                if (div !== v.div)   begin bad = 1; $display("FAIL %s div act=%0d exp=%0d", v.tag, div, v.div); end
                if (cmp !== v.cmp)   begin bad = 1; $display("FAIL %s cmp act=%0d exp=%0d", v.tag, cmp, v.cmp); end
                if (run !== v.run)   begin bad = 1; $display("FAIL %s run act=%0b exp=%0b", v.tag, run, v.run); end
                if (flag !== v.flag) begin bad = 1; $display("FAIL %s flag act=%0b exp=%0b", v.tag, flag, v.flag); end
                if (irq !== v.irq)   begin bad = 1; $display("FAIL %s irq act=%0b exp=%0b", v.tag, irq, v.irq); end
                if (dma !== v.dma)   begin bad = 1; $display("FAIL %s dma act=%0b exp=%0b", v.tag, dma, v.dma); end
                if (bad) n_bad++;
            end
        end
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        steps("R9 reset", 3);
        rst_n = 1;
        // R5: preload writes stay hidden until an update event.
        lim_wr = 1; lim_wd = 16'd4; div_wr = 1; div_wd = 16'd2; cmp_wr = 1; cmp_wd = 16'd7;
        step("R5 preload hidden");
        steps("R5 preload hidden", 2);
        sw_upd = 1; step("R5 sw update reload");
        flag_clr = 1; step("R9 clear");
        steps("R1 idle hold", 4);
        // R3: up counting with divide-by-3, overflow sets flag (R8).
        run_wr = 1; run_wd = 1; step("R3 start");
        steps("R3 up count", 40);
        // R8: wrap-only filter blocks the software source.
        flag_clr = 1; wrap_only = 1; step("R8 clear");
        sw_upd = 1; step("R8 sw filtered");
        steps("R8 wait ovf", 20);
        // R9: enables gate the requests; set wins over clear.
        irq_en = 1; step("R9 irq");
        dma_en = 1; irq_en = 0; step("R9 dma");
        flag_clr = 1; step("R9 clear");
        wrap_only = 0;
        // R6 / R7: inhibit blocks reload and flag, restart still happens.
        upd_inh = 1; lim_wr = 1; lim_wd = 16'd6; div_wr = 1; div_wd = 16'd1;
        step("R6 inhibit write");
        steps("R6 inhibit run", 20);
        sw_upd = 1; step("R7 restart inhibited");
        steps("R6 inhibit run", 5);
        // R4 / R7: slave reset while counting down reloads and restarts.
        upd_inh = 0; dir = 1; slv_rst = 1; step("R7 slave restart down");
        steps("R4 down count", 40);
        // R1 / R2: stop, then a trigger starts counting.
        run_wr = 1; run_wd = 0; step("R1 stop");
        steps("R1 stopped hold", 5);
        slv_trig = 1; run_wr = 1; run_wd = 0; step("R2 trigger wins");
        steps("R2 running", 6);
        // R10: software strobe on the exact overflow cycle.
        dir = 0; flag_clr = 1; step("R10 prep");
        for (int i = 0; i < 60; i++) begin
            if (m_run && m_pcnt == m_div && m_cnt == m_lim) break;
            step("R10 approach");
        end
        sw_upd = 1; step("R10 coincident");
        steps("R10 after", 4);
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule